// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block keeps the debug-mode state of a processor core and decides what happens on each debug-related event. Decode logic supplies three single-cycle event strobes: a software break instruction, a hardware debug match, and a trap return that carries a one-bit debug operand. The core also supplies its current trap-enable and supervisor flags. When a break or match arrives outside debug mode, the controller enters debug mode and raises a debug trap. It saves the current trap-enable and supervisor flags and tells the core to disable traps and force supervisor mode. Only one path leads out of debug mode: a trap return with debug operand 1, issued while traps are disabled. That return gives the saved flags back to the core. A misused trap return raises a sticky halt request.

The controller also owns a small bank of debug-only registers (control, break cause, break addresses). Software can write these and read them back only while the core is in debug mode. It also owns the two-bit saved-status register, which software may rewrite in debug mode before it exits. All outputs except the register read data are registered. Each takes effect one clock after the event that causes it.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, debug mode, halt, debug trap and flag update are all low, the saved-status register reads 00, and every debug register holds zero.
- R2: A break instruction or a hardware match, arriving while the core is not in debug mode and not halted, sets debug mode one cycle later. It also pulses the debug-trap output high for exactly that one cycle.
- R3: On entry, the saved-status register captures the current flags (bit 1 = trap-enable, bit 0 = supervisor). In the same cycle as the trap pulse, the flag-update output pulses with trap-enable 0 and supervisor 1.
- R4: A break or match arriving while already in debug mode is ignored: no trap pulse, no flag update, and the saved-status register is unchanged.
- R5: A trap return with debug operand 1, arriving in debug mode with trap-enable 0, clears debug mode one cycle later. In that cycle it pulses the flag update, carrying the trap-enable and supervisor values held in the saved-status register just before.
- R6: A trap return with debug operand 1 that arrives outside debug mode sets halt one cycle later, and debug mode stays clear.
- R7: Any trap return that arrives with trap-enable 1 sets halt one cycle later, whatever the operand and whatever the mode.
- R8: A trap return with debug operand 0 and trap-enable 0 changes nothing here: debug mode keeps its value, and no halt or flag update occurs.
- R9: Halt stays set until reset. While it is set, break, match, trap-return and saved-status writes have no effect on debug mode, trap, flag update or the saved status.
- R10: A saved-status write takes effect one cycle later only if the core is in debug mode. Outside debug mode the write is dropped.
- R11: A debug register is written at index `dreg_widx_i` only in debug mode and only if the index is below DREG_COUNT. Read data shows the indexed register while in debug mode. It reads zero outside debug mode and for indices at or above DREG_COUNT.
- R12: If a trap return and a break or match arrive in the same cycle, the trap return is acted on and the break or match is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_insn_i | input | 1 | Break instruction decoded this cycle |
| hw_match_i | input | 1 | Hardware debug match this cycle |
| trap_ret_i | input | 1 | Trap return decoded this cycle |
| ret_dbg_op_i | input | 1 | Debug operand of the trap return |
| cur_te_i | input | 1 | Current trap-enable flag of the core |
| cur_sup_i | input | 1 | Current supervisor flag of the core |
| sstat_we_i | input | 1 | Saved-status write strobe |
| sstat_wdata_i | input | 2 | Saved-status write value {te, sup} |
| dreg_we_i | input | 1 | Debug register write strobe |
| dreg_widx_i | input | IDX_W | Debug register write index |
| dreg_wdata_i | input | DATA_W | Debug register write value |
| dreg_ridx_i | input | IDX_W | Debug register read index |
| dbg_mode_o | output | 1 | Core is in debug mode |
| halt_o | output | 1 | Sticky halt request |
| dbg_trap_o | output | 1 | One-cycle debug trap request |
| flag_upd_o | output | 1 | Core must load the flags below |
| flag_te_o | output | 1 | Trap-enable value to load |
| flag_sup_o | output | 1 | Supervisor value to load |
| sstat_o | output | 2 | Saved-status register {te, sup} |
| dreg_rdata_o | output | DATA_W | Debug register read data |

## Verification
The hardest situations to reach are those that need the core to be in one mode while a conflicting event arrives. Examples are a return with operand 1 that races a break in the same cycle, and a rewritten saved status that must steer the flags given back on exit. The stimulus walks the controller into debug mode through a real break and rewrites the saved status. It then fires the exit return together with a break, so exit and entry collide. Halting cases start from fresh resets, so each misuse is reached from a known mode, and the bench then checks that later events leave the frozen state untouched.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

    typedef struct packed {
        logic te;
        logic sup;
    } flags_t;

    typedef struct packed {
        logic   in_dbg;
        logic   halted;
        logic   trap;
        logic   upd;
        flags_t upd_flags;
        flags_t saved;
    } ctl_state_t;

endpackage

// File: rtl/dbg_mode_core.sv
module dbg_mode_core
    import dbg_mode_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       brk_insn_i,
    input  logic       hw_match_i,
    input  logic       trap_ret_i,
    input  logic       ret_dbg_op_i,
    input  logic       cur_te_i,
    input  logic       cur_sup_i,
    input  logic       sstat_we_i,
    input  flags_t     sstat_wdata_i,
    output ctl_state_t state_o
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.trap      = 1'b0;
        st_d.upd       = 1'b0;
        st_d.upd_flags = '0;
        if (!st_q.halted) begin
            if (trap_ret_i) begin
                // returns win over break/match in the same cycle
                if (cur_te_i) begin
                    st_d.halted = 1'b1;
                end else if (ret_dbg_op_i) begin
                    if (!st_q.in_dbg) begin
                        st_d.halted = 1'b1;
                    end else begin
                        st_d.in_dbg    = 1'b0;
                        st_d.upd       = 1'b1;
                        st_d.upd_flags = st_q.saved;
                    end
                end
            end else if ((brk_insn_i || hw_match_i) && !st_q.in_dbg) begin
                st_d.in_dbg        = 1'b1;
                st_d.trap          = 1'b1;
                st_d.upd           = 1'b1;
                st_d.upd_flags.te  = 1'b0;
                st_d.upd_flags.sup = 1'b1;
                st_d.saved.te      = cur_te_i;
                st_d.saved.sup     = cur_sup_i;
            end
            if (st_q.in_dbg && sstat_we_i) begin
                st_d.saved = sstat_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/dbg_mode_regs.sv
module dbg_mode_regs #(
    parameter int DATA_W     = 32,
    parameter int DREG_COUNT = 6,
    parameter int IDX_W      = $clog2(DREG_COUNT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_dbg_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] regs_q [DREG_COUNT];

    for (genvar g = 0; g < DREG_COUNT; g++) begin : g_reg
        logic hit;
        assign hit = in_dbg_i && we_i && (widx_i == IDX_W'(g));
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                regs_q[g] <= '0;
            end else if (hit) begin
                regs_q[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DREG_COUNT; i++) begin
            if (in_dbg_i && ridx_i == IDX_W'(i)) begin
                rdata_o = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbg_mode_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DREG_COUNT = 6,
    parameter int IDX_W      = $clog2(DREG_COUNT)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              brk_insn_i,
    input  logic              hw_match_i,
    input  logic              trap_ret_i,
    input  logic              ret_dbg_op_i,
    input  logic              cur_te_i,
    input  logic              cur_sup_i,
    input  logic              sstat_we_i,
    input  logic [1:0]        sstat_wdata_i,
    input  logic              dreg_we_i,
    input  logic [IDX_W-1:0]  dreg_widx_i,
    input  logic [DATA_W-1:0] dreg_wdata_i,
    input  logic [IDX_W-1:0]  dreg_ridx_i,
    output logic              dbg_mode_o,
    output logic              halt_o,
    output logic              dbg_trap_o,
    output logic              flag_upd_o,
    output logic              flag_te_o,
    output logic              flag_sup_o,
    output logic [1:0]        sstat_o,
    output logic [DATA_W-1:0] dreg_rdata_o
);

    ctl_state_t st;
    flags_t     sst_wr;

    assign sst_wr.te  = sstat_wdata_i[1];
    assign sst_wr.sup = sstat_wdata_i[0];

    dbg_mode_core i_core (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .brk_insn_i   (brk_insn_i),
        .hw_match_i   (hw_match_i),
        .trap_ret_i   (trap_ret_i),
        .ret_dbg_op_i (ret_dbg_op_i),
        .cur_te_i     (cur_te_i),
        .cur_sup_i    (cur_sup_i),
        .sstat_we_i   (sstat_we_i),
        .sstat_wdata_i(sst_wr),
        .state_o      (st)
    );

    dbg_mode_regs #(
        .DATA_W    (DATA_W),
        .DREG_COUNT(DREG_COUNT),
        .IDX_W     (IDX_W)
    ) i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .in_dbg_i(st.in_dbg),
        .we_i    (dreg_we_i),
        .widx_i  (dreg_widx_i),
        .wdata_i (dreg_wdata_i),
        .ridx_i  (dreg_ridx_i),
        .rdata_o (dreg_rdata_o)
    );

    assign dbg_mode_o = st.in_dbg;
    assign halt_o     = st.halted;
    assign dbg_trap_o = st.trap;
    assign flag_upd_o = st.upd;
    assign flag_te_o  = st.upd_flags.te;
    assign flag_sup_o = st.upd_flags.sup;
    assign sstat_o    = {st.saved.te, st.saved.sup};

endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk #(
    parameter int DATA_W     = 32,
    parameter int DREG_COUNT = 6,
    parameter int IDX_W      = $clog2(DREG_COUNT)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              brk_insn_i,
    input logic              hw_match_i,
    input logic              trap_ret_i,
    input logic              ret_dbg_op_i,
    input logic              cur_te_i,
    input logic              cur_sup_i,
    input logic              dbg_mode_o,
    input logic              halt_o,
    input logic              dbg_trap_o,
    input logic              flag_upd_o,
    input logic              flag_te_o,
    input logic              flag_sup_o,
    input logic [1:0]        sstat_o,
    input logic [DATA_W-1:0] dreg_rdata_o
);

    assert_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((brk_insn_i || hw_match_i) && !trap_ret_i && !dbg_mode_o && !halt_o)
        |=> (dbg_mode_o && dbg_trap_o));

    assert_save_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((brk_insn_i || hw_match_i) && !trap_ret_i && !dbg_mode_o && !halt_o)
        |=> (sstat_o == $past({cur_te_i, cur_sup_i}) && flag_upd_o && !flag_te_o && flag_sup_o));

    assert_ignore_in_dbg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_mode_o && !trap_ret_i && (brk_insn_i || hw_match_i))
        |=> !dbg_trap_o);

    assert_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_ret_i && ret_dbg_op_i && !cur_te_i && dbg_mode_o && !halt_o)
        |=> (!dbg_mode_o && flag_upd_o && flag_te_o == $past(sstat_o[1])
             && flag_sup_o == $past(sstat_o[0])));

    assert_halt_te_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_ret_i && cur_te_i) |=> halt_o);

    assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> (halt_o && $stable(dbg_mode_o) && !dbg_trap_o));

    assert_read_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dbg_mode_o |-> (dreg_rdata_o == '0));

endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(
    .DATA_W    (DATA_W),
    .DREG_COUNT(DREG_COUNT),
    .IDX_W     (IDX_W)
) i_chk (.*);

// File: tb/test_dbg_mode_ctrl.sv
module test_dbg_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DREG_COUNT = 6;
    localparam int IDX_W      = $clog2(DREG_COUNT);

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              brk_insn_i, hw_match_i, trap_ret_i, ret_dbg_op_i;
    logic              cur_te_i, cur_sup_i, sstat_we_i, dreg_we_i;
    logic [1:0]        sstat_wdata_i;
    logic [IDX_W-1:0]  dreg_widx_i, dreg_ridx_i;
    logic [DATA_W-1:0] dreg_wdata_i;
    logic              dbg_mode_o, halt_o, dbg_trap_o, flag_upd_o, flag_te_o, flag_sup_o;
    logic [1:0]        sstat_o;
    logic [DATA_W-1:0] dreg_rdata_o;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    dbg_mode_ctrl #(.DATA_W(DATA_W), .DREG_COUNT(DREG_COUNT)) i_dbg_mode_ctrl (.*);

    typedef struct {
        logic [7:0]        v;   // {dbg, halt, trap, upd, fte, fsup, sstat}
        logic [DATA_W-1:0] rd;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // reference model state
    logic              m_dbg, m_halt;
    logic [1:0]        m_sst;
    logic [DATA_W-1:0] m_regs [DREG_COUNT];

    function automatic logic [7:0] act_vec();
        return {dbg_mode_o, halt_o, dbg_trap_o, flag_upd_o, flag_te_o, flag_sup_o, sstat_o};
    endfunction

    task automatic idle_in();
        brk_insn_i = 0; hw_match_i = 0; trap_ret_i = 0; ret_dbg_op_i = 0;
        cur_te_i = 0; cur_sup_i = 0; sstat_we_i = 0; sstat_wdata_i = 0;
        dreg_we_i = 0; dreg_widx_i = 0; dreg_wdata_i = 0; dreg_ridx_i = 0;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk_i);
        rst_ni = 0;
        idle_in();
        m_dbg = 0; m_halt = 0; m_sst = 0;
        for (int i = 0; i < DREG_COUNT; i++) m_regs[i] = '0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1;
        n_cmp++;
        if (act_vec() !== 8'h00 || dreg_rdata_o !== '0) begin
            n_bad++;
            $display("FAIL %s: got %h/%h expected 00/0", tag, act_vec(), dreg_rdata_o);
        end
    endtask

    // driver: inputs already set at a falling edge; predict and push
    task automatic commit(input string tag);
        exp_t e;
        logic trap, upd, fte, fsup, was_dbg;
        trap = 0; upd = 0; fte = 0; fsup = 0; was_dbg = m_dbg;
        if (!m_halt) begin
            if (trap_ret_i) begin
                if (cur_te_i) m_halt = 1;
                else if (ret_dbg_op_i) begin
                    if (!m_dbg) m_halt = 1;
                    else begin m_dbg = 0; upd = 1; fte = m_sst[1]; fsup = m_sst[0]; end
                end
            end else if ((brk_insn_i || hw_match_i) && !m_dbg) begin
                m_dbg = 1; trap = 1; upd = 1; fte = 0; fsup = 1;
                m_sst = {cur_te_i, cur_sup_i};
            end
            if (was_dbg && sstat_we_i) m_sst = sstat_wdata_i;
        end
        if (was_dbg && dreg_we_i && int'(dreg_widx_i) < DREG_COUNT)
            m_regs[dreg_widx_i] = dreg_wdata_i;
        e.v   = {m_dbg, m_halt, trap, upd, fte, fsup, m_sst};
        e.rd  = (m_dbg && int'(dreg_ridx_i) < DREG_COUNT) ? m_regs[dreg_ridx_i] : '0;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk_i);
        idle_in();
    endtask

    // monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk_i);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (act_vec() !== e.v || dreg_rdata_o !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s: got %b/%h expected %b/%h",
                             e.tag, act_vec(), dreg_rdata_o, e.v, e.rd);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle_in();
        do_reset("R1 reset state");
        commit("R1 idle after reset");

        // enter through break with te=1 sup=0
        brk_insn_i = 1; cur_te_i = 1; cur_sup_i = 0;
        commit("R2 R3 break entry");
        commit("R2 trap pulse ends");
        hw_match_i = 1; cur_te_i = 1; cur_sup_i = 1;
        commit("R4 match ignored in debug");
        brk_insn_i = 1;
        commit("R4 break ignored in debug");

        dreg_we_i = 1; dreg_widx_i = 2; dreg_wdata_i = 32'hA5A5_0001;
        commit("R11 write in debug");
        dreg_ridx_i = 2;
        commit("R11 read back in debug");
        dreg_we_i = 1; dreg_widx_i = 6; dreg_wdata_i = 32'hDEAD_BEEF;
        commit("R11 out of range write");
        dreg_ridx_i = 6;
        commit("R11 out of range read zero");

        sstat_we_i = 1; sstat_wdata_i = 2'b01;
        commit("R10 status write in debug");
        trap_ret_i = 1; ret_dbg_op_i = 0;
        commit("R8 return op0 stays in debug");
        trap_ret_i = 1; ret_dbg_op_i = 1;
        commit("R5 exit restores flags");
        dreg_ridx_i = 2;
        commit("R11 read zero outside debug");

        dreg_we_i = 1; dreg_widx_i = 2; dreg_wdata_i = 32'hFFFF_FFFF;
        commit("R11 write dropped outside");
        sstat_we_i = 1; sstat_wdata_i = 2'b10;
        commit("R10 status write dropped outside");
        hw_match_i = 1; cur_te_i = 0; cur_sup_i = 0; dreg_ridx_i = 2;
        commit("R2 match entry keeps old reg");

        trap_ret_i = 1; ret_dbg_op_i = 1; brk_insn_i = 1;
        commit("R12 return beats break");
        commit("R12 no trap after collision");

        trap_ret_i = 1; ret_dbg_op_i = 0;
        commit("R8 return op0 outside");
        trap_ret_i = 1; ret_dbg_op_i = 1;
        commit("R6 op1 outside halts");
        brk_insn_i = 1;
        commit("R9 break ignored while halted");

        do_reset("R1 second reset");
        brk_insn_i = 1; cur_te_i = 0; cur_sup_i = 1;
        commit("R2 entry again");
        trap_ret_i = 1; ret_dbg_op_i = 0; cur_te_i = 1;
        commit("R7 return with traps on halts");
        trap_ret_i = 1; ret_dbg_op_i = 1;
        commit("R9 exit ignored while halted");
        sstat_we_i = 1; sstat_wdata_i = 2'b11;
        commit("R9 status write ignored while halted");

        do_reset("R1 third reset");
        trap_ret_i = 1; ret_dbg_op_i = 0; cur_te_i = 1;
        commit("R7 return with traps on outside");
        commit("R9 halt holds");

        @(negedge clk_i);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule